// File: doc/BRIEF.md
# Interrupt Priority Status Controller

This block holds the interrupt fields of a processor status word. These are a global enable bit and a current running priority, where a lower number means a more urgent priority. Three kinds of event can arrive in a cycle: an external hardware interrupt with its own number, a trap request carrying an immediate number, and an internal exception with a fixed number. The block decides in the same cycle whether an event is taken. It raises a take strobe together with the accepted event number. On the next clock edge it loads the priority field with that number and drops the enable, so nesting stays off until software turns it back on.

Software reaches the fields in three ways. A full status write loads both fields at once. Two single-purpose strobes set or clear only the enable. Vector fetch, context save and the rest of the status word are handled elsewhere.

Top module: `irq_prio_status`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, the following cycle shows ie = 0 and prio = 63 (all ones).
- R2: A hardware request is taken only when ie = 1 and hw_num is below prio as an unsigned number. hw_num equal to or above prio, or ie = 0, rejects it.
- R3: A trap request is always taken, whatever ie and prio hold.
- R4: take and take_num are combinational in the cycle of the request. The winner is the trap (take_num = trap_imm) first, then the exception (take_num = EXC_NUM, default 9), then the hardware interrupt (take_num = hw_num).
- R5: After a cycle with take = 1, prio equals that cycle's take_num and ie = 0. This overrides any write made in the same cycle.
- R6: An exception request is taken only when ie = 1.
- R7: en_set makes ie = 1 on the next cycle and en_clr makes it 0, with prio unchanged. If both are high, the clear wins.
- R8: st_wr loads ie from st_wdata[6] and prio from st_wdata[5:0]. An en_set or en_clr in the same cycle overrides the enable value from st_wdata.
- R9: With no take and no write of any kind, ie and prio hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 1 | External interrupt request |
| hw_num | input | 6 | External interrupt number |
| trap_req | input | 1 | Trap instruction request |
| trap_imm | input | 6 | Trap immediate number |
| exc_req | input | 1 | Internal exception request |
| st_wr | input | 1 | Full status field write strobe |
| st_wdata | input | 7 | {enable, priority} write data |
| en_set | input | 1 | Set-enable write strobe |
| en_clr | input | 1 | Clear-enable write strobe |
| ie | output | 1 | Current enable bit |
| prio | output | 6 | Current running priority |
| take | output | 1 | Event accepted this cycle |
| take_num | output | 6 | Number of the accepted event |

## Verification
take and take_num depend only on the present inputs and the present state. The bench therefore samples them one time unit after it drives the inputs, which is well before the next rising edge. ie and prio pass through one register, so each value is due one edge after its cause. The bench compares them at the following falling edge against a model state that it advanced with that cycle's stimulus. Directed cases cover the equal-priority boundary, traps while disabled, and colliding writes. Random cycles with a fixed seed cover the rest.

// File: rtl/ipsc_pkg.sv
// Package: shared widths and the event-source encoding for the
// interrupt priority status controller.
// Assumes: priority width of 6 bits unless overridden at the top.
package ipsc_pkg;
    localparam int IPSC_PRIO_W = 6;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_EXC  = 2'd2,
        SRC_HW   = 2'd3
    } ipsc_src_e;
endpackage

// File: rtl/ipsc_arbiter.sv
// Module: ipsc_arbiter
// Decides in the same cycle which pending event, if any, is accepted.
// The order is trap, then internal exception, then hardware interrupt.
// Assumes: ie and prio are the registered state of the current cycle.
module ipsc_arbiter
    import ipsc_pkg::*;
#(
    parameter int                PRIO_W  = IPSC_PRIO_W,
    parameter logic [PRIO_W-1:0] EXC_NUM = PRIO_W'(9)
) (
    input  logic              hw_req,
    input  logic [PRIO_W-1:0] hw_num,
    input  logic              trap_req,
    input  logic [PRIO_W-1:0] trap_imm,
    input  logic              exc_req,
    input  logic              ie,
    input  logic [PRIO_W-1:0] prio,
    output logic              take,
    output logic [PRIO_W-1:0] take_num
);
    ipsc_src_e src;
    logic      hw_ok;

    // Qualify the hardware request against the enable and the priority.
    always_comb hw_ok = hw_req && ie && (hw_num < prio);

    // Pick the winning source in the fixed order.
    always_comb begin
        if (trap_req)            src = SRC_TRAP;
        else if (exc_req && ie)  src = SRC_EXC;
        else if (hw_ok)          src = SRC_HW;
        else                     src = SRC_NONE;
    end

    // Drive the strobe and the accepted number from the winner.
    always_comb begin
        take = (src != SRC_NONE);
        unique case (src)
            SRC_TRAP: take_num = trap_imm;
            SRC_EXC:  take_num = EXC_NUM;
            SRC_HW:   take_num = hw_num;
            default:  take_num = '0;
        endcase
    end

    // R3: a trap is never refused.
    always_comb a_r3_trap_taken: assert (!trap_req || take);
    // R2: a hardware win implies enable set and strictly lower number.
    always_comb a_r2_hw_gate: assert (src != SRC_HW || (ie && hw_num < prio));
    // R6: an exception is never taken with the enable clear.
    always_comb a_r6_exc_gate: assert (src != SRC_EXC || ie);
endmodule

// File: rtl/ipsc_status_reg.sv
// Module: ipsc_status_reg
// Holds the enable bit and the priority field. It applies a full write
// first, then the set/clear strobes, then an accepted event, so that
// each later source overrides the earlier ones.
// Assumes: synchronous active-low reset; take_num is valid with take.
module ipsc_status_reg #(
    parameter int PRIO_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_wr,
    input  logic [PRIO_W:0]   st_wdata,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              take,
    input  logic [PRIO_W-1:0] take_num,
    output logic              ie,
    output logic [PRIO_W-1:0] prio
);
    localparam logic [PRIO_W-1:0] PRIO_LOWEST = '1;

    logic              ie_d;
    logic [PRIO_W-1:0] prio_d;

    // Next-state selection in rising order of precedence.
    always_comb begin
        ie_d   = ie;
        prio_d = prio;
        if (st_wr) begin
            ie_d   = st_wdata[PRIO_W];
            prio_d = st_wdata[PRIO_W-1:0];
        end
        if (en_set) ie_d = 1'b1;
        if (en_clr) ie_d = 1'b0;
        if (take) begin
            ie_d   = 1'b0;
            prio_d = take_num;
        end
    end

    // State register with reset to disabled and lowest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            prio <= PRIO_LOWEST;
        end else begin
            ie   <= ie_d;
            prio <= prio_d;
        end
    end

    // R1: reset leaves the block disabled at the lowest priority.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!ie && prio == PRIO_LOWEST));
    // R5: an accepted event loads its number and drops the enable.
    a_r5_take_update: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!ie && prio == $past(take_num)));
    // R7: clear strobe without event leaves enable low, priority kept.
    a_r7_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !take && !st_wr) |=> (!ie && $stable(prio)));
    // R9: no event and no writes keeps both fields.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !st_wr && !en_set && !en_clr) |=> ($stable(ie) && $stable(prio)));
endmodule

// File: rtl/irq_prio_status.sv
// Module: irq_prio_status
// Top of the interrupt priority status controller. It joins the
// same-cycle acceptance logic to the enable/priority state register.
// Assumes: one clock domain, synchronous active-low reset.
module irq_prio_status
    import ipsc_pkg::*;
#(
    parameter int                PRIO_W  = IPSC_PRIO_W,
    parameter logic [PRIO_W-1:0] EXC_NUM = PRIO_W'(9)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_req,
    input  logic [PRIO_W-1:0] hw_num,
    input  logic              trap_req,
    input  logic [PRIO_W-1:0] trap_imm,
    input  logic              exc_req,
    input  logic              st_wr,
    input  logic [PRIO_W:0]   st_wdata,
    input  logic              en_set,
    input  logic              en_clr,
    output logic              ie,
    output logic [PRIO_W-1:0] prio,
    output logic              take,
    output logic [PRIO_W-1:0] take_num
);
    ipsc_arbiter #(
        .PRIO_W  (PRIO_W),
        .EXC_NUM (EXC_NUM)
    ) u_arb (
        .hw_req   (hw_req),
        .hw_num   (hw_num),
        .trap_req (trap_req),
        .trap_imm (trap_imm),
        .exc_req  (exc_req),
        .ie       (ie),
        .prio     (prio),
        .take     (take),
        .take_num (take_num)
    );

    ipsc_status_reg #(
        .PRIO_W (PRIO_W)
    ) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_wr    (st_wr),
        .st_wdata (st_wdata),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .take     (take),
        .take_num (take_num),
        .ie       (ie),
        .prio     (prio)
    );

    // R8: a full write with no event and no strobes lands as written.
    a_r8_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !take && !en_set && !en_clr) |=> ({ie, prio} == $past(st_wdata)));
endmodule

// File: tb/irq_prio_status_tb.sv
module irq_prio_status_tb;
    localparam int          W   = 6;
    localparam logic [W-1:0] EXC = 6'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req = 0, trap_req = 0, exc_req = 0, st_wr = 0, en_set = 0, en_clr = 0;
    logic [W-1:0] hw_num = '0, trap_imm = '0;
    logic [W:0]   st_wdata = '0;
    logic         ie, take;
    logic [W-1:0] prio, take_num;

    int n_run = 0, n_fail = 0;
    logic         m_ie;
    logic [W-1:0] m_prio;
    bit           done = 0;

    always #2 clk = ~clk;

    irq_prio_status u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_num(hw_num),
        .trap_req(trap_req), .trap_imm(trap_imm), .exc_req(exc_req),
        .st_wr(st_wr), .st_wdata(st_wdata), .en_set(en_set), .en_clr(en_clr),
        .ie(ie), .prio(prio), .take(take), .take_num(take_num)
    );

    // Expected acceptance per the requirements (R2, R3, R4, R6).
    function automatic logic [W:0] exp_take(logic s_ie, logic [W-1:0] s_prio);
        if (trap_req)                           return {1'b1, trap_imm};
        if (exc_req && s_ie)                    return {1'b1, EXC};
        if (hw_req && s_ie && hw_num < s_prio)  return {1'b1, hw_num};
        return '0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        hw_req = 0; trap_req = 0; exc_req = 0; st_wr = 0; en_set = 0; en_clr = 0;
    endtask

    // One cycle: check state, drive, check take, advance model (R5, R7, R8, R9).
    task automatic step(string req);
        logic [W:0] t;
        chk({req, " state"}, {m_ie, m_prio}, {ie, prio});
        #1;
        t = exp_take(m_ie, m_prio);
        chk({req, " take"}, {take, take_num}, t);
        if (st_wr) {m_ie, m_prio} = st_wdata;
        if (en_set) m_ie = 1;
        if (en_clr) m_ie = 0;
        if (t[W]) begin m_ie = 0; m_prio = t[W-1:0]; end
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 ie", ie, 0);
        chk("R1 prio", prio, 63);
        rst_n = 1; m_ie = 0; m_prio = 6'd63;
        // R3 trap while disabled
        trap_req = 1; trap_imm = 6'd40; hw_req = 1; hw_num = 1; step("R3");
        step("R5 trap load");
        // R7 set only, priority kept; R6 exc blocked first
        exc_req = 1; step("R6 blocked");
        en_set = 1; step("R7 set");
        // R2 boundary: equal rejected, below taken
        hw_req = 1; hw_num = 6'd40; step("R2 equal");
        hw_req = 1; hw_num = 6'd39; step("R2 below");
        step("R5 hw load");
        // R4 order: exc beats hw
        en_set = 1; step("R7 set");
        exc_req = 1; hw_req = 1; hw_num = 0; step("R4 exc over hw");
        // R8 full write then overridden by clear; R7 both strobes
        st_wr = 1; st_wdata = {1'b1, 6'd20}; en_clr = 1; step("R8 override");
        st_wr = 1; st_wdata = {1'b0, 6'd30}; en_set = 1; step("R8 set override");
        en_set = 1; en_clr = 1; step("R7 both");
        // R5 event beats write
        st_wr = 1; st_wdata = {1'b1, 6'd5}; trap_req = 1; trap_imm = 6'd50; step("R5 over write");
        step("R9 hold");
        // random cycles
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 16;
            hw_req = ($urandom % 2) == 1; hw_num = 6'($urandom);
            trap_req = r == 0; trap_imm = 6'($urandom);
            exc_req = r == 1 || r == 2;
            st_wr = r == 3 || r == 4; st_wdata = 7'($urandom);
            en_set = r >= 5 && r <= 9; en_clr = r == 10 || r == 5;
            step("RND R2 R4 R9");
        end
        // R1 reset mid-run
        st_wr = 1; st_wdata = {1'b1, 6'd3}; @(negedge clk); clear_in();
        rst_n = 0; @(negedge clk);
        chk("R1 rerun ie", ie, 0);
        chk("R1 rerun prio", prio, 63);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule